// File: doc/BRIEF.md
# Mirrored Polyphase Coefficient Table Loader

This block fills a scaler's polyphase coefficient register bank from a compact, half-table filter description. The caller presents nine stored phases of seven 12-bit taps, a base address and a tap-count mode, then pulses a start request. The block then issues one 32-bit register write per cycle until all sixteen table phases are in place, and signals completion with a single-cycle done pulse.

Only the lower half of the table plus the centre phase is supplied. The upper seven table phases are derived by mirroring: the source phase is counted down from the top of the stored half and the tap order within each phase is reversed. Each phase's seven taps are packed into three 32-bit words, with taps straddling word boundaries, and the three words go to three sub-banks spaced one bank stride apart. A short mode loads a five-tap filter into the same layout, leaving the unused slots zero.

The start inputs are captured when a request is accepted, so the caller may change them freely while a load is under way.

Top module: `coef_table_loader`

## Requirements
- R1: While reset is asserted and after it is released with no start request, `wr_en_o`, `busy_o` and `done_o` are all low.
- R2: A start request seen while idle makes `wr_en_o` high from the next cycle for exactly 48 consecutive cycles, one write per cycle, with `busy_o` high during those cycles.
- R3: Writes go in table-phase order 0 to 15, and within each phase word 0, word 1, word 2; the address of word w of table phase p is base + w*0x40 + p*4, modulo 2^ADDR_W.
- R4: Table phases 0 to 8 use stored phase p, with slot j taking tap j of that phase (seven-tap mode).
- R5: Table phases 9 to 15 use stored phase 16-p (7 down to 1), with slot j taking tap 6-j of that phase (seven-tap mode).
- R6: With slots s0..s6, word 0 is {4'b0, s0, s1, s2[11:8]}, word 1 is {4'b0, s2[7:0], s3, s4[11:4]} and word 2 is {4'b0, s4[3:0], s5, s6}; bits 31:28 are always zero.
- R7: When `short_mode_i` is 1 at the accepted start, slot j (j = 0..4) takes tap j+1 for phases 0 to 8 and tap 5-j for phases 9 to 15, and slots 5 and 6 are zero.
- R8: In the cycle after the 48th write, `done_o` is high for exactly one cycle with `wr_en_o` and `busy_o` low.
- R9: A start request while busy is ignored, and base address, mode and coefficients are taken only at the accepted start: changes to them during a load do not alter any write of that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, taken only while idle |
| short_mode_i | input | 1 | 1 selects five-tap loading, 0 seven-tap |
| base_addr_i | input | ADDR_W | Byte address of the coefficient bank |
| coef_i | input | STORED*7*12 | Stored taps; tap t of phase s at bits (s*7+t)*12 +: 12 |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | ADDR_W | Write byte address |
| wr_data_o | output | 32 | Write data |
| busy_o | output | 1 | High while the load is in progress |
| done_o | output | 1 | One-cycle pulse after the last write |

## Verification
The bound checker takes for granted that no new load is started in the cycle of the done pulse being counted as part of the previous run; a write strobe only falls after a completed run, so the run-length and address-step properties hold as long as reset is not asserted mid-run, which the stimulus never does. Address stepping is checked only relative to the previous write, so the checker makes no assumption about the base address, and the bench sweeps bases that wrap the address space. The bench holds every input stable except for one deliberate disturbance pulse during a run, and computes each expected word from the requirement formulas over both modes and several coefficient patterns.

// File: rtl/coefld_pkg.sv
package coefld_pkg;

    // Fixed packing format of the coefficient bank
    localparam int unsigned TAP_W      = 12;
    localparam int unsigned TAP_CNT    = 7;
    localparam int unsigned SHORT_TAPS = 5;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned PAD_W      = WORD_W - 28;

    typedef logic [TAP_W-1:0]         tap_t;
    typedef tap_t [TAP_CNT-1:0]       phase_taps_t;
    typedef logic [WORD_W-1:0]        word_t;

    // Sub-bank select: the three packed words of one phase
    typedef enum logic [1:0] {
        SUB_0 = 2'd0,
        SUB_1 = 2'd1,
        SUB_2 = 2'd2
    } sub_bank_e;

    // Pack seven slots into the word chosen by the sub-bank select
    function automatic word_t pack_word(phase_taps_t s, sub_bank_e sel);
        word_t w;
        case (sel)
            SUB_0:   w = {{PAD_W{1'b0}}, s[0], s[1], s[2][11:8]};
            SUB_1:   w = {{PAD_W{1'b0}}, s[2][7:0], s[3], s[4][11:4]};
            SUB_2:   w = {{PAD_W{1'b0}}, s[4][3:0], s[5], s[6]};
            default: w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/coefld_seq.sv
module coefld_seq
    import coefld_pkg::*;
#(
    parameter int unsigned NUM_PHASES = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    output logic                          load_o,
    output logic                          busy_o,
    output logic                          done_o,
    output logic [$clog2(NUM_PHASES)-1:0] phase_o,
    output sub_bank_e                     sub_o
);

    localparam int unsigned PH_W = $clog2(NUM_PHASES);
    localparam logic [PH_W-1:0] LAST_PHASE = PH_W'(NUM_PHASES - 1);

    typedef struct packed {
        logic            busy;
        logic            done;
        logic [PH_W-1:0] phase;
        sub_bank_e       sub;
    } seq_t;

    seq_t s_d, s_q;
    logic load_d;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        load_d   = 1'b0;
        if (!s_q.busy) begin
            if (start_i) begin
                s_d.busy  = 1'b1;
                s_d.phase = '0;
                s_d.sub   = SUB_0;
                load_d    = 1'b1;
            end
        end else begin
            case (s_q.sub)
                SUB_0:   s_d.sub = SUB_1;
                SUB_1:   s_d.sub = SUB_2;
                default: begin
                    s_d.sub = SUB_0;
                    if (s_q.phase == LAST_PHASE) begin
                        s_d.busy = 1'b0;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.phase = s_q.phase + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{busy: 1'b0, done: 1'b0, phase: '0, sub: SUB_0};
        end else begin
            s_q <= s_d;
        end
    end

    assign load_o  = load_d;
    assign busy_o  = s_q.busy;
    assign done_o  = s_q.done;
    assign phase_o = s_q.phase;
    assign sub_o   = s_q.sub;

endmodule

// File: rtl/coefld_store.sv
module coefld_store
    import coefld_pkg::*;
#(
    parameter int unsigned STORED = 9,
    parameter int unsigned ADDR_W = 12
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              load_i,
    input  logic [STORED*TAP_CNT*TAP_W-1:0]   coef_i,
    input  logic [ADDR_W-1:0]                 base_i,
    input  logic                              short_i,
    output logic [STORED*TAP_CNT*TAP_W-1:0]   coef_o,
    output logic [ADDR_W-1:0]                 base_o,
    output logic                              short_o
);

    localparam int unsigned COEF_BITS = STORED * TAP_CNT * TAP_W;

    typedef struct packed {
        logic [COEF_BITS-1:0] coef;
        logic [ADDR_W-1:0]    base;
        logic                 short_mode;
    } store_t;

    store_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.coef       = coef_i;
            r_d.base       = base_i;
            r_d.short_mode = short_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign coef_o  = r_q.coef;
    assign base_o  = r_q.base;
    assign short_o = r_q.short_mode;

endmodule

// File: rtl/coefld_pack.sv
module coefld_pack
    import coefld_pkg::*;
#(
    parameter int unsigned NUM_PHASES = 16,
    parameter int unsigned STORED     = NUM_PHASES / 2 + 1
) (
    input  logic [STORED*TAP_CNT*TAP_W-1:0]   coef_i,
    input  logic                              short_i,
    input  logic [$clog2(NUM_PHASES)-1:0]     phase_i,
    input  sub_bank_e                         sub_i,
    output word_t                             data_o
);

    localparam int unsigned PH_W = $clog2(NUM_PHASES);
    localparam int unsigned HALF = NUM_PHASES / 2;
    localparam int unsigned TI_W = $clog2(TAP_CNT);

    phase_taps_t stored_q [STORED];

    // Slice the flat input into per-phase tap groups
    for (genvar gs = 0; gs < STORED; gs++) begin : g_phase
        for (genvar gt = 0; gt < TAP_CNT; gt++) begin : g_tap
            assign stored_q[gs][gt] = coef_i[(gs*TAP_CNT+gt)*TAP_W +: TAP_W];
        end
    end

    logic            mirror;
    logic [PH_W:0]   src_idx;
    phase_taps_t     cur;
    phase_taps_t     slot;
    logic [TI_W-1:0] tsel;

    always_comb begin
        mirror  = ({1'b0, phase_i} > (PH_W+1)'(HALF));
        src_idx = mirror ? ((PH_W+1)'(NUM_PHASES) - {1'b0, phase_i})
                         : {1'b0, phase_i};

        cur = '0;
        for (int i = 0; i < STORED; i++) begin
            if (src_idx == (PH_W+1)'(i)) begin
                cur = stored_q[i];
            end
        end

        slot = '0;
        tsel = '0;
        for (int j = 0; j < TAP_CNT; j++) begin
            if (short_i) begin
                if (j < SHORT_TAPS) begin
                    tsel    = mirror ? TI_W'(SHORT_TAPS - j) : TI_W'(j + 1);
                    slot[j] = cur[tsel];
                end else begin
                    slot[j] = '0;
                end
            end else begin
                tsel    = mirror ? TI_W'(TAP_CNT - 1 - j) : TI_W'(j);
                slot[j] = cur[tsel];
            end
        end

        data_o = pack_word(slot, sub_i);
    end

endmodule

// File: rtl/coef_table_loader.sv
module coef_table_loader
    import coefld_pkg::*;
#(
    parameter int unsigned NUM_PHASES = 16,
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned STORED     = NUM_PHASES / 2 + 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_i,
    input  logic                              short_mode_i,
    input  logic [ADDR_W-1:0]                 base_addr_i,
    input  logic [STORED*TAP_CNT*TAP_W-1:0]   coef_i,
    output logic                              wr_en_o,
    output logic [ADDR_W-1:0]                 wr_addr_o,
    output logic [WORD_W-1:0]                 wr_data_o,
    output logic                              busy_o,
    output logic                              done_o
);

    localparam int unsigned PH_W        = $clog2(NUM_PHASES);
    localparam int unsigned COEF_BITS   = STORED * TAP_CNT * TAP_W;
    localparam int unsigned WORD_BYTES  = WORD_W / 8;
    localparam int unsigned BANK_STRIDE = NUM_PHASES * WORD_BYTES;

    logic                 load;
    logic                 busy;
    logic                 done;
    logic [PH_W-1:0]      phase;
    sub_bank_e            sub;
    logic [COEF_BITS-1:0] coef_q;
    logic [ADDR_W-1:0]    base_q;
    logic                 short_q;
    word_t                data;

    coefld_seq #(
        .NUM_PHASES (NUM_PHASES)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .busy_o  (busy),
        .done_o  (done),
        .phase_o (phase),
        .sub_o   (sub)
    );

    coefld_store #(
        .STORED (STORED),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .coef_i  (coef_i),
        .base_i  (base_addr_i),
        .short_i (short_mode_i),
        .coef_o  (coef_q),
        .base_o  (base_q),
        .short_o (short_q)
    );

    coefld_pack #(
        .NUM_PHASES (NUM_PHASES),
        .STORED     (STORED)
    ) u_pack (
        .coef_i  (coef_q),
        .short_i (short_q),
        .phase_i (phase),
        .sub_i   (sub),
        .data_o  (data)
    );

    always_comb begin
        wr_addr_o = base_q
                  + ADDR_W'(ADDR_W'(sub) * ADDR_W'(BANK_STRIDE))
                  + ADDR_W'(ADDR_W'(phase) * ADDR_W'(WORD_BYTES));
        wr_data_o = busy ? data : '0;
    end

    assign wr_en_o = busy;
    assign busy_o  = busy;
    assign done_o  = done;

endmodule

// File: rtl/coef_table_loader_chk.sv
module coef_table_loader_chk #(
    parameter int unsigned NUM_PHASES = 16,
    parameter int unsigned ADDR_W     = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic              busy,
    input logic              done
);

    localparam int unsigned TOTAL  = NUM_PHASES * 3;
    localparam int unsigned CNT_W  = $clog2(TOTAL + 1);
    localparam logic [ADDR_W-1:0] BANK = ADDR_W'(NUM_PHASES * 4);
    localparam logic [ADDR_W-1:0] BACK = ADDR_W'(4) - ADDR_W'(2 * NUM_PHASES * 4);

    logic [CNT_W-1:0] run_q;
    logic [1:0]       word_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            word_q <= '0;
        end else if (wr_en) begin
            run_q  <= run_q + 1'b1;
            word_q <= (word_q == 2'd2) ? 2'd0 : word_q + 2'd1;
        end else begin
            run_q  <= '0;
            word_q <= '0;
        end
    end

    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_en) |-> (run_q == CNT_W'(TOTAL))); // R2

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (run_q < CNT_W'(TOTAL))); // R2

    AST_SUB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word_q != 2'd0) |-> (wr_addr == $past(wr_addr) + BANK)); // R3

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word_q == 2'd0 && run_q != '0) |-> (wr_addr == $past(wr_addr) + BACK)); // R3

    AST_TOP_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data[31:28] == 4'h0)); // R6

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_en) |-> done); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!wr_en && !busy)); // R8

endmodule

bind coef_table_loader coef_table_loader_chk #(
    .NUM_PHASES (NUM_PHASES),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en_o),
    .wr_addr (wr_addr_o),
    .wr_data (wr_data_o),
    .busy    (busy_o),
    .done    (done_o)
);

// File: tb/test_coef_table_loader.sv
module test_coef_table_loader;

    localparam int NPH    = 16;
    localparam int NST    = 9;
    localparam int NTAP   = 7;
    localparam int AW     = 12;
    localparam int CBITS  = NST * NTAP * 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             short_mode_i = 1'b0;
    logic [AW-1:0]    base_addr_i = '0;
    logic [CBITS-1:0] coef_i = '0;
    logic             wr_en_o;
    logic [AW-1:0]    wr_addr_o;
    logic [31:0]      wr_data_o;
    logic             busy_o;
    logic             done_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 1'b0;

    logic [11:0] cb [NST][NTAP];

    always #10 clk = ~clk;

    coef_table_loader #(
        .NUM_PHASES (NPH),
        .ADDR_W     (AW)
    ) i_coef_table_loader (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .short_mode_i (short_mode_i),
        .base_addr_i  (base_addr_i),
        .coef_i       (coef_i),
        .wr_en_o      (wr_en_o),
        .wr_addr_o    (wr_addr_o),
        .wr_data_o    (wr_data_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(int p, int w, bit sm);
        logic [11:0] s [NTAP];
        int src;
        bit mir;
        mir = (p > NPH / 2);
        src = mir ? NPH - p : p;
        for (int j = 0; j < NTAP; j++) begin
            if (sm) s[j] = (j < 5) ? cb[src][mir ? 5 - j : j + 1] : 12'h000;
            else    s[j] = cb[src][mir ? 6 - j : j];
        end
        case (w)
            0:       return {4'h0, s[0], s[1], s[2][11:8]};
            1:       return {4'h0, s[2][7:0], s[3], s[4][11:4]};
            default: return {4'h0, s[4][3:0], s[5], s[6]};
        endcase
    endfunction

    task automatic run(bit sm, int seed, logic [AW-1:0] base, bit disturb);
        logic [AW-1:0] ea;
        string rq;
        for (int s = 0; s < NST; s++)
            for (int t = 0; t < NTAP; t++) begin
                cb[s][t] = 12'((seed * 37 + s * 181 + t * 29 + s * t * 7 + seed * t * 613) & 32'hFFF);
                coef_i[(s*NTAP+t)*12 +: 12] = cb[s][t];
            end
        short_mode_i = sm;
        base_addr_i  = base;
        start_i      = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < NPH * 3; k++) begin
            int p;
            int w;
            p  = k / 3;
            w  = k % 3;
            ea = AW'(int'(base) + w * NPH * 4 + p * 4);
            check(wr_en_o && busy_o, "R2 write strobe", {30'd0, busy_o, wr_en_o}, 32'd3);
            check(wr_addr_o == ea, "R3 address", {20'd0, wr_addr_o}, {20'd0, ea});
            if (disturb)      rq = "R9 latched data";
            else if (sm)      rq = "R7 short mode";
            else if (p <= 8)  rq = "R4 R6 direct phase";
            else              rq = "R5 R6 mirrored phase";
            check(wr_data_o == exp_word(p, w, sm), rq, wr_data_o, exp_word(p, w, sm));
            if (disturb && k == 20) begin
                start_i      = 1'b1;
                short_mode_i = ~sm;
                base_addr_i  = ~base;
                coef_i       = ~coef_i;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        check(done_o && !wr_en_o && !busy_o, "R8 done after last",
              {29'd0, done_o, wr_en_o, busy_o}, 32'd4);
        @(negedge clk);
        check(!done_o && !wr_en_o, "R8 done single",
              {30'd0, done_o, wr_en_o}, 32'd0);
        if (disturb)
            check(!busy_o, "R9 start while busy ignored", {31'd0, busy_o}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!wr_en_o && !busy_o && !done_o, "R1 reset state",
              {29'd0, wr_en_o, busy_o, done_o}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!wr_en_o && !busy_o && !done_o, "R1 idle after reset",
              {29'd0, wr_en_o, busy_o, done_o}, 32'd0);
        for (int m = 0; m < 2; m++)
            for (int sd = 1; sd <= 3; sd++) begin
                run(m[0], sd * 5 + m, AW'(12'h100 * sd), 1'b0);
                @(negedge clk);
            end
        run(1'b0, 11, 12'hFC0, 1'b0);
        run(1'b1, 12, 12'hFE4, 1'b0);
        run(1'b0, 21, 12'h200, 1'b1);
        @(negedge clk);
        run(1'b1, 22, 12'h340, 1'b1);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !finished) begin
                finished = 1'b1;
                checks++;
                fails++;
                $display("FAIL watchdog actual=%0d expected=<100000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

endmodule